// File: doc/BRIEF.md
# Erase-Before-Program Non-Volatile Word Store

This block is the controller of a small non-volatile word store holding four 9-bit words. Each word carries an 8-bit tap setting in bits [7:0] and a buffer-mode flag in bit 8. A client issues one request at a time: read a word, erase a word, or program a word. Every accepted request occupies the store for an internal access time, and `busy` is high for that time. The results of a request appear in the first cycle in which `busy` is low again.

Programming is only allowed on a word that has been erased since it was last programmed. A program request against a word that is not erased is refused: the word keeps its value and an error flag is raised. An active-low write-protect input is sampled when a request is accepted. While it is low, erase and program requests change nothing, and reads still complete normally. A blocked or refused request gives only a short acknowledge period instead of the full access time. Reset models power-up. The storage cells keep their contents across it, and word 0 is recalled into the read-data register automatically.

Top module: `nvs_store`

## Requirements
- R1: A read request (`req_op` = 2'b00) returns the addressed 9-bit word on `rd_data` (bit 8 mode, bits [7:0] tap) in the first cycle `busy` is low after the request.
- R2: An erase request (`req_op` = 2'b01) with write-protect inactive sets the addressed word to 9'h1FF and marks it erased.
- R3: A program request (`req_op` = 2'b10) on an erased word stores `req_wdata` and clears the erased mark. A program request on a word that is not erased leaves the word unchanged, sets `prog_err` and gives a busy period of `ACK_CYC` cycles.
- R4: When `wp_n` is low as a request is accepted, erase and program leave all words unchanged, `prog_err` stays 0 and busy lasts `ACK_CYC` cycles. A read under write-protect still lasts `BUSY_CYC` cycles and returns data.
- R5: `wp_n` is sampled only in the accept cycle. Changing it while `busy` is high does not alter the outcome of the request in progress.
- R6: A read, an erase, or a program that is granted holds `busy` high for exactly `BUSY_CYC` cycles after the accepting edge.
- R7: Requests presented while `busy` is high are ignored. A request held valid across the end of an access is accepted on the first edge at which `busy` is low, so `busy` is low for exactly one cycle in between.
- R8: After reset is released, `busy` stays high for `BUSY_CYC` cycles, then `rd_data` holds word 0. Reset does not alter stored words.
- R9: Operation code 2'b11 is never accepted: `busy` stays low and nothing changes.
- R10: `prog_err` reflects the last completed request. It is cleared by any completion that was not a refused program, and it is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 read, 01 erase, 10 program, 11 reserved |
| req_addr | input | 2 | Word index |
| req_wdata | input | 9 | Word to program (bit 8 mode, [7:0] tap) |
| wp_n | input | 1 | Write-protect, active low |
| rd_data | output | 9 | Last word read or recalled |
| busy | output | 1 | Internal access in progress |
| prog_err | output | 1 | Last completion was a refused program |

## Verification
The completion of one access and the arrival of the next request can fall on the same clock edge. The bench provokes this by holding a read request valid across the whole busy period. It judges the result by requiring exactly one low cycle of `busy` before the next access begins. A second collision is between a write-protect change and an access in flight. The bench toggles `wp_n` in the cycle after acceptance and judges the outcome by reading the word back. A request that arrives mid-access is also checked for having no effect on the stored word.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int TAP_W  = 8;
    localparam int WORD_W = TAP_W + 1;

    typedef struct packed {
        logic             mode;
        logic [TAP_W-1:0] tap;
    } nv_word_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_ERASE = 2'b01,
        OP_PROG  = 2'b10,
        OP_NONE  = 2'b11
    } nv_op_e;

    function automatic logic op_accepted(input nv_op_e op);
        return op != OP_NONE;
    endfunction

    function automatic logic op_mutates(input nv_op_e op);
        return (op == OP_ERASE) || (op == OP_PROG);
    endfunction

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int BUSY_CYC = 100000,
    parameter int ACK_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic short_len,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LONG_LOAD  = CW'(BUSY_CYC - 1);
    localparam logic [CW-1:0] SHORT_LOAD = CW'(ACK_CYC - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b1;
            cnt_q  <= LONG_LOAD;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= short_len ? SHORT_LOAD : LONG_LOAD;
        end
    end

    // R6: the end of an access always drops busy on the next cycle
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R6: a start always raises busy
    a_r6_start_raises: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

endmodule

// File: rtl/nvs_cells.sv
module nvs_cells
    import nvs_pkg::*;
#(
    parameter int NWORDS = 4,
    localparam int AW    = $clog2(NWORDS)
) (
    input  logic                  clk,
    input  logic                  er_en,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  nv_word_t              wdata,
    output nv_word_t [NWORDS-1:0] words,
    output logic [NWORDS-1:0]     erased
);
    // Cells are not reset: their content survives a power-up reset.
    for (genvar i = 0; i < NWORDS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (er_en && (addr == AW'(i))) begin
                words[i]  <= '1;
                erased[i] <= 1'b1;
            end else if (wr_en && (addr == AW'(i))) begin
                words[i]  <= wdata;
                erased[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nvs_store.sv
module nvs_store
    import nvs_pkg::*;
#(
    parameter int NWORDS   = 4,
    parameter int BUSY_CYC = 100000,
    parameter int ACK_CYC  = 2,
    localparam int AW      = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              wp_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              prog_err
);
    typedef struct packed {
        nv_op_e        op;
        logic [AW-1:0] addr;
        nv_word_t      data;
        logic          blocked;
        logic          refused;
    } pend_t;

    nv_word_t [NWORDS-1:0] words;
    logic [NWORDS-1:0]     erased;
    pend_t                 pend;
    nv_word_t              rd_q;
    logic                  err_q;
    logic                  done;
    logic                  accept;
    logic                  blk;
    logic                  rfs;
    logic                  er_en;
    logic                  wr_en;
    nv_op_e                op_in;

    assign op_in  = nv_op_e'(req_op);
    assign accept = req_valid && !busy && op_accepted(op_in);
    assign blk    = op_mutates(op_in) && !wp_n;
    assign rfs    = (op_in == OP_PROG) && wp_n && !erased[req_addr];

    nvs_timer #(
        .BUSY_CYC (BUSY_CYC),
        .ACK_CYC  (ACK_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .short_len (blk || rfs),
        .busy      (busy),
        .done      (done)
    );

    // Power-up: the pending access is a read of word 0 (the recall).
    always_ff @(posedge clk) begin
        if (rst) begin
            pend.op      <= OP_READ;
            pend.addr    <= '0;
            pend.data    <= '0;
            pend.blocked <= 1'b0;
            pend.refused <= 1'b0;
        end else if (accept) begin
            pend.op      <= op_in;
            pend.addr    <= req_addr;
            pend.data    <= nv_word_t'(req_wdata);
            pend.blocked <= blk;
            pend.refused <= rfs;
        end
    end

    assign er_en = done && (pend.op == OP_ERASE) && !pend.blocked;
    assign wr_en = done && (pend.op == OP_PROG) && !pend.blocked && !pend.refused;

    nvs_cells #(
        .NWORDS (NWORDS)
    ) u_cells (
        .clk    (clk),
        .er_en  (er_en),
        .wr_en  (wr_en),
        .addr   (pend.addr),
        .wdata  (pend.data),
        .words  (words),
        .erased (erased)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            err_q <= 1'b0;
        end else if (done) begin
            err_q <= pend.refused;
            if (pend.op == OP_READ) begin
                rd_q <= words[pend.addr];
            end
        end
    end

    assign rd_data  = rd_q;
    assign prog_err = err_q;

    // R3: the cell array is only written on a word marked erased
    a_r3_prog_needs_erase: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> erased[pend.addr]);

    // R2: an erase leaves the word all ones and marked erased
    a_r2_erase_result: assert property (@(posedge clk) disable iff (rst)
        er_en |=> (words[$past(pend.addr)] == '1) && erased[$past(pend.addr)]);

    // R7: stored words never move except at the end of an access
    a_r7_cells_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(words));

    // R6: an accepted request at the ports raises busy
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_op != 2'b11)) |=> busy);

    // R9: the reserved code never starts an access
    a_r9_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && (!req_valid || (req_op == 2'b11))) |=> !busy);

    // R10: the error flag only rises after a program completes
    a_r10_err_from_prog: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_err) |-> $past(pend.op == OP_PROG));

endmodule

// File: tb/sim_nvs_store.sv
module sim_nvs_store;
    import nvs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int B = 12;
    localparam int A = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [1:0] req_addr = 2'b00;
    logic [8:0] req_wdata = '0;
    logic       wp_n = 1'b1;
    logic [8:0] rd_data;
    logic       busy;
    logic       prog_err;

    int total = 0;
    int bad = 0;
    logic [8:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_store #(.NWORDS(4), .BUSY_CYC(B), .ACK_CYC(A)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .wp_n(wp_n),
        .rd_data(rd_data), .busy(busy), .prog_err(prog_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] a,
                         input logic [8:0] d, output int len);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(len);
    endtask

    task automatic rd(input logic [1:0] a, output logic [8:0] v);
        int len;
        issue(2'b00, a, '0, len);
        v = rd_data;
    endtask

    task automatic t_first_reset;
        int n;
        repeat (3) @(negedge clk);
        chk("R8 busy in reset", busy, 1);
        chk("R10 err after reset", prog_err, 0);
        rst = 1'b0;
        wait_idle(n);
        chk("R8 recall length", n, B);
    endtask

    task automatic t_erase_all;
        int len;
        logic [8:0] v;
        for (int i = 0; i < 4; i++) begin
            issue(2'b01, 2'(i), '0, len);
            chk("R6 erase length", len, B);
            model[i] = 9'h1FF;
        end
        rd(2'd2, v);
        chk("R2 erased word reads 1FF", v, 9'h1FF);
    endtask

    task automatic t_program;
        int len;
        logic [8:0] v;
        logic [8:0] vals [4];
        vals[0] = 9'h15A; vals[1] = 9'h0C3; vals[2] = 9'h100; vals[3] = 9'h07E;
        for (int i = 0; i < 4; i++) begin
            issue(2'b10, 2'(i), vals[i], len);
            chk("R6 program length", len, B);
            chk("R3 granted program no err", prog_err, 0);
            model[i] = vals[i];
        end
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk("R1 read back word", v, model[i]);
        end
    endtask

    task automatic t_refuse;
        int len;
        logic [8:0] v;
        issue(2'b10, 2'd1, 9'h0AA, len);
        chk("R3 refused short ack", len, A);
        chk("R3 refused sets err", prog_err, 1);
        rd(2'd1, v);
        chk("R3 refused word unchanged", v, model[1]);
        chk("R10 read clears err", prog_err, 0);
    endtask

    task automatic t_wp;
        int len;
        logic [8:0] v;
        issue(2'b01, 2'd2, '0, len);
        model[2] = 9'h1FF;
        wp_n = 1'b0;
        issue(2'b01, 2'd1, '0, len);
        chk("R4 blocked erase short ack", len, A);
        issue(2'b10, 2'd2, 9'h033, len);
        chk("R4 blocked program short ack", len, A);
        chk("R4 blocked program no err", prog_err, 0);
        issue(2'b00, 2'd1, '0, len);
        chk("R4 read under wp full length", len, B);
        chk("R4 blocked erase left word", rd_data, model[1]);
        rd(2'd2, v);
        chk("R4 blocked program left word", v, 9'h1FF);
        wp_n = 1'b1;
    endtask

    task automatic t_wp_sample;
        int len;
        logic [8:0] v;
        @(negedge clk);
        wp_n = 1'b1; req_valid = 1'b1; req_op = 2'b01; req_addr = 2'd3;
        @(negedge clk);
        req_valid = 1'b0; wp_n = 1'b0;
        wait_idle(len);
        wp_n = 1'b1;
        model[3] = 9'h1FF;
        rd(2'd3, v);
        chk("R5 erase granted at accept", v, 9'h1FF);
        @(negedge clk);
        wp_n = 1'b0; req_valid = 1'b1; req_op = 2'b01; req_addr = 2'd0;
        @(negedge clk);
        req_valid = 1'b0; wp_n = 1'b1;
        wait_idle(len);
        chk("R5 blocked at accept short", len, A);
        rd(2'd0, v);
        chk("R5 blocked at accept word kept", v, model[0]);
    endtask

    task automatic t_busy_ignore;
        int len;
        logic [8:0] v;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle(len);
        chk("R7 no second access", busy, 0);
        rd(2'd1, v);
        chk("R7 erase during busy ignored", v, model[1]);
    endtask

    task automatic t_back_to_back;
        int n;
        int gap;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = 2'd1;
        @(negedge clk);
        wait_idle(n);
        gap = 0;
        while (!busy && gap < 10) begin
            gap++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R7 held request gap", gap, 1);
        chk("R1 first read data", rd_data, model[1]);
        wait_idle(n);
    endtask

    task automatic t_reserved;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; req_addr = 2'd0; req_wdata = 9'h000;
        @(negedge clk);
        chk("R9 reserved not accepted", busy, 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 still idle", busy, 0);
    endtask

    task automatic t_recall;
        int n;
        logic [8:0] v;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wait_idle(n);
        chk("R8 recall busy length", n, B);
        chk("R8 recalled word 0", rd_data, model[0]);
        rd(2'd2, v);
        chk("R8 word kept over reset", v, model[2]);
    endtask

    initial begin
        t_first_reset();
        t_erase_all();
        t_program();
        t_refuse();
        t_wp();
        t_wp_sample();
        t_busy_ignore();
        t_back_to_back();
        t_reserved();
        t_recall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule